// File: doc/BRIEF.md
# Transmit Buffer Status Controller

This block keeps the status of three transmit message buffers in a CAN-style controller. For each buffer it stores an empty flag, an interrupt enable, an abort request and an abort acknowledge. Software reaches these through a small register port with byte-wide data and a two-bit address. A transmit engine reports two kinds of per-buffer event: a message was sent successfully, and an abort completed successfully.

A buffer is scheduled for sending while its empty flag is 0. Software loads a message and then clears the flag by writing a one to it. The controller sets the flag again when the message has gone out or when an abort finishes. The block tells the transmit engine which buffers it may send, tells the software side which buffers it must not access, and raises one registered interrupt while any enabled buffer is empty. Listen mode stops new transmissions and blocks flag clears. Initialization mode holds the interrupt enables at zero.

Top module: `txbuf_status_ctrl`

Register map (bit i belongs to buffer i, bits 7:3 read as zero): address 0 holds the empty flags, address 1 the interrupt enables, address 2 the abort requests, and address 3 the abort acknowledges, which are read-only.

## Requirements
- R1: After reset the empty flags read 3'b111, and the enables, abort requests, abort acknowledges, tx_sched, buf_blocked and tx_irq are all 0. Bits 7:3 of every register read 0.
- R2: Writing data to address 0 clears each empty flag whose data bit is 1. Data bits that are 0, and bits 7:3, have no effect.
- R3: A sent_ok pulse for buffer i sets empty flag i at the next clock edge. If software clears the same flag in the same cycle, the flag is still set.
- R4: Writing a 1 to bit i of address 2 sets abort request i only while buffer i is scheduled (flag 0). When the flag is set by any cause, the request clears.
- R5: An abort_ok pulse for buffer i takes effect only while abort request i is set. It then sets empty flag i and abort acknowledge i. Without a pending request it changes nothing.
- R6: When software clears an empty flag, the matching abort acknowledge clears too.
- R7: While listen_mode is 1, writes to address 0 leave the flags unchanged and tx_sched is all 0.
- R8: tx_sched[i] is 1 when flag i is 0 and listen mode is off. buf_blocked[i] is 1 exactly while flag i is 0.
- R9: One cycle after the state changes, tx_irq equals the OR over the buffers of (empty flag AND interrupt enable).
- R10: Writes to address 1 take effect only when init_req and init_ack are both 0. While both are 1, the enables are forced to 0.
- R11: Address 3 is read-only. Writing to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr_en | input | 1 | Write strobe, captured at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| init_req | input | 1 | Initialization request |
| init_ack | input | 1 | Initialization acknowledge |
| listen_mode | input | 1 | Listen-only mode active |
| sent_ok | input | 3 | Per-buffer pulse: message sent successfully |
| abort_ok | input | 3 | Per-buffer pulse: abort completed |
| tx_sched | output | 3 | Per-buffer transmission allowed |
| buf_blocked | output | 3 | Per-buffer software access blocked |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
Every bit of state is stored once, in a register, so a wrong flag shows up on tx_sched and buf_blocked in the same cycle it is captured. It also shows up in the address 0 readback, and on tx_irq one cycle later. A wrong abort request or acknowledge is visible at once on read addresses 2 and 3. Its worst effect is an abort that is accepted or ignored by mistake, and that shows on the empty flag at the next clock edge. A wrong enable, for example one that survives initialization mode, shows on address 1 and, one edge later, as a spurious or missing tx_irq.

// File: rtl/txbuf_pkg.sv
// Package: shared constants and the register address map for the
// transmit buffer status controller. No logic lives here.
package txbuf_pkg;
    localparam int NUM_BUF = 3;
    localparam int REG_W   = 8;
    localparam int ADDR_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_EMPTY = 2'd0,
        ADR_IEN   = 2'd1,
        ADR_ABRQ  = 2'd2,
        ADR_ABAK  = 2'd3
    } txbuf_addr_e;
endpackage

// File: rtl/txbuf_slice.sv
// Module: txbuf_slice
// State of one transmit buffer: empty flag, abort request and abort
// acknowledge. A hardware set always wins over a clear from software.
// Assumes: clr_req and abt_wr are one-cycle write strobes that are
// already decoded from the data bits; sent and abort_done are pulses
// from the transmit engine.
module txbuf_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_req,
    input  logic abt_wr,
    input  logic sent,
    input  logic abort_done,
    input  logic listen,
    output logic empty,
    output logic abt_req,
    output logic abt_ack
);
    logic abort_take;
    logic hw_set;
    logic sw_clr;

    // Decide which events are accepted this cycle
    always_comb begin
        abort_take = abort_done & abt_req;
        hw_set     = sent | abort_take;
        sw_clr     = clr_req & ~listen & ~hw_set;
    end

    // Empty flag: reset to 1, set by hardware, cleared by software
    always_ff @(posedge clk) begin
        if (!rst_n)      empty <= 1'b1;
        else if (hw_set) empty <= 1'b1;
        else if (sw_clr) empty <= 1'b0;
    end

    // Abort request: set only while scheduled, dropped when the flag is set
    always_ff @(posedge clk) begin
        if (!rst_n)                abt_req <= 1'b0;
        else if (hw_set)           abt_req <= 1'b0;
        else if (abt_wr && !empty) abt_req <= 1'b1;
    end

    // Abort acknowledge: set by an accepted abort, dropped by a software clear
    always_ff @(posedge clk) begin
        if (!rst_n)          abt_ack <= 1'b0;
        else if (abort_take) abt_ack <= 1'b1;
        else if (sw_clr)     abt_ack <= 1'b0;
    end

    // R4: a pending request implies the buffer is scheduled
    a_r4_req_needs_sched: assert property (@(posedge clk) disable iff (!rst_n)
        abt_req |-> !empty);
    // R3: a send report always leaves the buffer empty
    a_r3_sent_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        sent |=> empty);
    // R6: a flag that falls never leaves its acknowledge high
    a_r6_ack_follows_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(empty) |-> !abt_ack);
    // R7: in listen mode an empty buffer stays empty
    a_r7_listen_keeps_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (listen && empty) |=> empty);
    // R5: an abort without a pending request raises no acknowledge
    a_r5_stray_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_done && !abt_req && !abt_ack) |=> !abt_ack);
endmodule

// File: rtl/txbuf_regif.sv
// Module: txbuf_regif
// Register port: decodes writes into per-buffer strobes, holds the
// interrupt enables, and multiplexes readback.
// Assumes: reg_wr_en is qualified by the caller. Reads are combinational
// and have no side effects.
module txbuf_regif
    import txbuf_pkg::*;
#(
    parameter int NB     = NUM_BUF,
    parameter int DW     = REG_W,
    parameter int AW     = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr_en,
    input  logic [DW-1:0] reg_wdata,
    input  logic          init_req,
    input  logic          init_ack,
    input  logic [NB-1:0] empty,
    input  logic [NB-1:0] abt_req,
    input  logic [NB-1:0] abt_ack,
    output logic [NB-1:0] clr_req,
    output logic [NB-1:0] abt_wr,
    output logic [NB-1:0] ien,
    output logic [DW-1:0] reg_rdata
);
    localparam int PAD = DW - NB;

    logic          init_active;
    logic          ien_wr_ok;
    logic [NB-1:0] wbits;
    logic          unused_wdata_hi;

    assign wbits           = reg_wdata[NB-1:0];
    assign unused_wdata_hi = ^reg_wdata[DW-1:NB];

    // Classify the initialization handshake state
    always_comb begin
        init_active = init_req & init_ack;
        ien_wr_ok   = ~init_req & ~init_ack;
    end

    // Decode write strobes for the flag and abort-request registers
    always_comb begin
        clr_req = '0;
        abt_wr  = '0;
        if (reg_wr_en && reg_addr == ADR_EMPTY) clr_req = wbits;
        if (reg_wr_en && reg_addr == ADR_ABRQ)  abt_wr  = wbits;
    end

    // Interrupt enables: held at zero in init mode, writable only outside it
    always_ff @(posedge clk) begin
        if (!rst_n || init_active)                            ien <= '0;
        else if (reg_wr_en && ien_wr_ok && reg_addr == ADR_IEN) ien <= wbits;
    end

    // Readback multiplexer with zero padding above the buffer bits
    always_comb begin
        unique case (reg_addr)
            ADR_EMPTY: reg_rdata = {{PAD{1'b0}}, empty};
            ADR_IEN:   reg_rdata = {{PAD{1'b0}}, ien};
            ADR_ABRQ:  reg_rdata = {{PAD{1'b0}}, abt_req};
            default:   reg_rdata = {{PAD{1'b0}}, abt_ack};
        endcase
    end

    // R10: initialization mode leaves the enables at zero
    a_r10_init_holds_ien: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req && init_ack) |=> (ien == '0));
    // R10: a half-finished handshake blocks enable updates
    a_r10_no_write_in_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req != init_ack) |=> $stable(ien));
endmodule

// File: rtl/txbuf_irq.sv
// Module: txbuf_irq
// Registered transmit interrupt: OR over all buffers of flag AND enable.
// Assumes: empty and ien are registered state, stable between edges.
module txbuf_irq #(
    parameter int NB = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] empty,
    input  logic [NB-1:0] ien,
    output logic          irq
);
    logic [NB-1:0] hit;

    // Per-buffer request terms, one per generate lane
    for (genvar i = 0; i < NB; i++) begin : g_hit
        assign hit[i] = empty[i] & ien[i];
    end

    // Register the combined request
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |hit;
    end

    // R9: the request follows the enabled empty flags one cycle later
    a_r9_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == $past(|(empty & ien))));
endmodule

// File: rtl/txbuf_status_ctrl.sv
// Module: txbuf_status_ctrl (top)
// Status and interrupt logic for the transmit buffers: register port,
// per-buffer state slices, and the scheduling, blocking and interrupt outputs.
// Assumes: sent_ok and abort_ok are single-cycle pulses in the clk domain.
module txbuf_status_ctrl
    import txbuf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr_en,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic                init_req,
    input  logic                init_ack,
    input  logic                listen_mode,
    input  logic [NUM_BUF-1:0]  sent_ok,
    input  logic [NUM_BUF-1:0]  abort_ok,
    output logic [NUM_BUF-1:0]  tx_sched,
    output logic [NUM_BUF-1:0]  buf_blocked,
    output logic                tx_irq
);
    logic [NUM_BUF-1:0] empty;
    logic [NUM_BUF-1:0] abt_req;
    logic [NUM_BUF-1:0] abt_ack;
    logic [NUM_BUF-1:0] clr_req;
    logic [NUM_BUF-1:0] abt_wr;
    logic [NUM_BUF-1:0] ien;

    txbuf_regif #(.NB(NUM_BUF), .DW(REG_W), .AW(ADDR_W)) u_regif (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .init_req(init_req), .init_ack(init_ack),
        .empty(empty), .abt_req(abt_req), .abt_ack(abt_ack),
        .clr_req(clr_req), .abt_wr(abt_wr), .ien(ien),
        .reg_rdata(reg_rdata)
    );

    for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
        txbuf_slice u_slice (
            .clk(clk), .rst_n(rst_n),
            .clr_req(clr_req[i]), .abt_wr(abt_wr[i]),
            .sent(sent_ok[i]), .abort_done(abort_ok[i]),
            .listen(listen_mode),
            .empty(empty[i]), .abt_req(abt_req[i]), .abt_ack(abt_ack[i])
        );
    end

    txbuf_irq #(.NB(NUM_BUF)) u_irq (
        .clk(clk), .rst_n(rst_n), .empty(empty), .ien(ien), .irq(tx_irq)
    );

    // Scheduling and access-block outputs drawn from the flags
    always_comb begin
        buf_blocked = ~empty;
        tx_sched    = ~empty & {NUM_BUF{~listen_mode}};
    end

    // R8: no transmission is offered while listening
    a_r8_no_sched_listen: assert property (@(posedge clk) disable iff (!rst_n)
        listen_mode |-> (tx_sched == '0));
    // R8: a buffer offered for sending is always blocked to software
    a_r8_sched_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_sched & ~buf_blocked) == '0));
endmodule

// File: tb/txbuf_status_ctrl_tb.sv
module txbuf_status_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       init_req = 1'b0, init_ack = 1'b0, listen_mode = 1'b0;
    logic [2:0] sent_ok = '0, abort_ok = '0;
    logic [2:0] tx_sched, buf_blocked;
    logic       tx_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int         kind;   // 0..3 register read, 4 sched, 5 blocked, 6 irq
        logic [7:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #5 clk = ~clk;

    txbuf_status_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .init_req(init_req),
        .init_ack(init_ack), .listen_mode(listen_mode), .sent_ok(sent_ok),
        .abort_ok(abort_ok), .tx_sched(tx_sched), .buf_blocked(buf_blocked),
        .tx_irq(tx_irq)
    );

    // Monitor: pop one expected item per falling edge and compare
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            if (it.kind < 4) reg_addr = it.kind[1:0];
            #1;
            case (it.kind)
                4:       act = {5'b0, tx_sched};
                5:       act = {5'b0, buf_blocked};
                6:       act = {7'b0, tx_irq};
                default: act = reg_rdata;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic expect_item(input int kind, input logic [7:0] exp, input string tag);
        sb_item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic drain();
        wait (sb_q.size() == 0);
        @(posedge clk);
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [2:0] s, input logic [2:0] ab);
        @(posedge clk); #1;
        sent_ok = s; abort_ok = ab;
        @(posedge clk); #1;
        sent_ok = '0; abort_ok = '0;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Driver
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        expect_item(0, 8'h07, "R1 flags"); expect_item(1, 8'h00, "R1 ien");
        expect_item(2, 8'h00, "R1 abrq"); expect_item(3, 8'h00, "R1 abak");
        expect_item(4, 8'h00, "R1 sched"); expect_item(5, 8'h00, "R1 blocked");
        expect_item(6, 8'h00, "R1 irq");
        drain();
        // R2 write-one-to-clear
        wr(0, 8'h00); expect_item(0, 8'h07, "R2 zero write"); drain();
        wr(0, 8'h01); expect_item(0, 8'h06, "R2 clear bit0");
        expect_item(4, 8'h01, "R8 sched"); expect_item(5, 8'h01, "R8 blocked"); drain();
        wr(0, 8'hF8); expect_item(0, 8'h06, "R2 high bits ignored"); drain();
        // R9 interrupt
        wr(1, 8'h07); tick();
        expect_item(1, 8'h07, "R10 ien write"); expect_item(6, 8'h01, "R9 irq on"); drain();
        wr(0, 8'h06); tick();
        expect_item(0, 8'h00, "R2 clear all"); expect_item(6, 8'h00, "R9 irq off"); drain();
        // R3 sent sets flag; set beats simultaneous clear
        pulse(3'b010, 3'b000); tick();
        expect_item(0, 8'h02, "R3 sent"); expect_item(6, 8'h01, "R9 irq after sent"); drain();
        @(posedge clk); #1;
        reg_addr = 0; reg_wdata = 8'h02; reg_wr_en = 1'b1; sent_ok = 3'b010;
        @(posedge clk); #1;
        reg_wr_en = 1'b0; sent_ok = '0;
        expect_item(0, 8'h02, "R3 set wins"); drain();
        // R4 abort requests
        wr(2, 8'h07); expect_item(2, 8'h05, "R4 req on scheduled only"); drain();
        pulse(3'b000, 3'b010);
        expect_item(0, 8'h02, "R5 stray abort flags"); expect_item(3, 8'h00, "R5 stray abort ack"); drain();
        pulse(3'b000, 3'b001);
        expect_item(0, 8'h03, "R5 abort flag"); expect_item(3, 8'h01, "R5 abort ack");
        expect_item(2, 8'h04, "R4 req cleared by abort"); drain();
        pulse(3'b100, 3'b000);
        expect_item(0, 8'h07, "R3 sent buf2"); expect_item(2, 8'h00, "R4 req cleared by send");
        expect_item(3, 8'h01, "R5 ack kept"); drain();
        // R11 read-only ack, R6 clear drops ack
        wr(3, 8'hFF); expect_item(3, 8'h01, "R11 ack read-only"); drain();
        wr(0, 8'h01); expect_item(0, 8'h06, "R6 flag"); expect_item(3, 8'h00, "R6 ack cleared"); drain();
        // R7 listen mode
        @(posedge clk); #1 listen_mode = 1'b1;
        expect_item(4, 8'h00, "R7 sched off"); expect_item(5, 8'h01, "R8 blocked in listen"); drain();
        wr(0, 8'h06); expect_item(0, 8'h06, "R7 clear ignored"); drain();
        @(posedge clk); #1 listen_mode = 1'b0;
        expect_item(4, 8'h01, "R8 sched back"); drain();
        // R10 initialization mode
        @(posedge clk); #1 init_req = 1'b1;
        wr(1, 8'h02); expect_item(1, 8'h07, "R10 write blocked in handshake"); drain();
        @(posedge clk); #1 init_ack = 1'b1;
        tick(); tick();
        expect_item(1, 8'h00, "R10 held at zero"); expect_item(6, 8'h00, "R9 irq masked"); drain();
        wr(1, 8'h07); expect_item(1, 8'h00, "R10 write ignored"); drain();
        @(posedge clk); #1 init_req = 1'b0; init_ack = 1'b0;
        wr(1, 8'h02); tick();
        expect_item(1, 8'h02, "R10 writable again"); expect_item(6, 8'h01, "R9 irq buf1"); drain();
        #5;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule